// File: doc/BRIEF.md
# Handshaked Serial Character Transmitter

This block turns one 7-bit character into an asynchronous serial frame on a single line. A frame is a low start bit, the seven data bits starting with the least significant, a parity bit, and a high stop bit. Every bit lasts a whole number of system clocks. That number is a parameter, computed as the clock frequency divided by the bit rate. When no frame is being sent, the line rests high.

The host controls each transfer with a four-phase handshake. It places the character and the parity choice on the inputs, raises the request, and keeps it high. The block answers by raising its busy flag and starting the frame. Busy falls once the stop bit has been on the line for a full bit period. The host then drops the request. The block does not look at the request again until it has seen the request low.

Inside the block, a bit-period tick generator is restarted at the start of each frame. A 9-bit load-and-shift register holds the start bit, the data and the parity bit, and it fills with ones as it shifts. A frame bit counter counts from 0 to 9. A control state machine drives the busy flag from a register.

Top module: `ser_tx_frame`

## Requirements
- R1: While reset is applied and after reset, before any request, the line output is 1 and busy is 0.
- R2: When the request is high in the idle state, both busy and the line change on the next clock edge: busy goes to 1 and the line goes to 0, and this start bit begins.
- R3: After the start bit, the seven data bits appear on the line in order, from data bit 0 to data bit 6.
- R4: The ninth bit is the parity bit. When parity select is 0, the parity bit is the XOR of the data bits, which gives an even count of ones over data and parity. When parity select is 1, the parity bit is the inverse of that XOR, which gives an odd count.
- R5: The tenth bit is a stop bit of 1. Busy falls exactly 10 bit periods after the clock edge on which it rose, and the line is 1 from that point on.
- R6: Every frame bit stays on the line for exactly CLKS_PER_BIT clocks, where CLKS_PER_BIT = CLK_HZ / BAUD.
- R7: After busy falls, a request that is still held high starts no new frame: busy stays 0 and the line stays 1 until the request has been low.
- R8: Once the request has been low for one clock, raising it again on the next clock starts a new frame with the same timing as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block |
| tx_data | input | DATA_W (7) | Character to send. It is sampled on the clock edge that starts the frame |
| tx_send | input | 1 | Transfer request. The host holds it high until busy falls |
| tx_odd | input | 1 | Parity select: 0 gives even parity, 1 gives odd parity |
| tx_busy | output | 1 | High while a frame is on the line. Driven directly by a register |
| txd | output | 1 | Serial line output. It rests at 1 |

## Verification
The bench sends every one of the 128 characters twice, once with even parity and once with odd parity. The line is compared with the expected bit on every clock of every frame. This finds a wrong bit order, a wrong parity sense for any data weight, and a bit period that is one clock too long or too short anywhere in the frame. In the sweep the request goes high again on the clock right after it was released, which tests back-to-back acceptance. A few frames instead hold the request high for many clocks after busy falls, which tests that a stale request is not accepted again. All-zero and all-one characters are included, so the parity logic is checked at both extremes of data weight.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } tx_state_e;

endpackage

// File: rtl/ser_tx_bit_timer.sv
module ser_tx_bit_timer #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int TW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart || cnt_q == LAST) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST) && !restart;

  // R6: one clock after a restart there is never a tick
  p_no_tick_after_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R6: a tick is never followed directly by another tick
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ser_tx_bit_counter.sv
module ser_tx_bit_counter #(
  parameter int LIMIT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       incr,
  output logic [$clog2(LIMIT)-1:0]   count,
  output logic                       wrap
);

  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)             cnt_d = '0;
    else if (incr) begin
      if (cnt_q == TOP)    cnt_d = '0;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign wrap  = incr && !clear && (cnt_q == TOP);

  // R5: the count never goes past the last frame bit
  p_count_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  input  logic              odd_sel,
  output logic              line
);

  localparam int FW = DATA_W + 2;

  logic [FW-1:0] sr_q, sr_d;
  logic          par;

  assign par = (^data) ^ odd_sel;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = {par, data, 1'b0};
    else if (shift) sr_d = {1'b1, sr_q[FW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign line = sr_q[0];

  // R5: each shift pushes a one in at the top
  p_fill_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> sr_q[FW-1]);

  // R2: a load always puts a zero start bit on the line
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !line);

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame #(
  parameter int CLK_HZ = 4_800_000,
  parameter int BAUD   = 300,
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_send,
  input  logic              tx_odd,
  output logic              tx_busy,
  output logic              txd
);
  import ser_tx_pkg::*;

  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
  localparam int FRAME_BITS   = DATA_W + 3;
  localparam int CW           = $clog2(FRAME_BITS);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  tx_state_e     state_q, state_d;
  logic          busy_q, busy_d;
  logic          tick, restart, load, shift_en;
  logic          cnt_clear, wrap;
  logic [CW-1:0] bit_idx;

  // next state and control
  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    cnt_clear = 1'b0;
    shift_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_send) begin
          load      = 1'b1;
          cnt_clear = 1'b1;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          shift_en = 1'b1;
          if (wrap) state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!tx_send) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    busy_d = (state_d == ST_SHIFT);
  end

  assign restart = (state_q != ST_SHIFT);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
    end
  end

  assign tx_busy = busy_q;

  ser_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .restart (restart),
    .tick    (tick)
  );

  ser_tx_bit_counter #(.LIMIT(FRAME_BITS)) u_count (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clear (cnt_clear),
    .incr  (shift_en),
    .count (bit_idx),
    .wrap  (wrap)
  );

  ser_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load    (load),
    .shift   (shift_en),
    .data    (tx_data),
    .odd_sel (tx_odd),
    .line    (txd)
  );

  // R1: the line rests high in idle
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_IDLE) |-> (txd && !tx_busy));

  // R2: request in idle raises busy and starts the start bit
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_IDLE && tx_send) |=> (tx_busy && !txd));

  // R5: busy falls with the line high and the bit counter back at zero
  p_end_frame_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(tx_busy) |-> (txd && bit_idx == '0));

  // R7: a request held after completion starts nothing
  p_hold_ignored_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_DONE && tx_send) |=> (!tx_busy && txd));

endmodule

// File: tb/ser_tx_frame_test.sv
module ser_tx_frame_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 160;
  localparam int T_BAUD     = 10;
  localparam int CPB        = T_CLK_HZ / T_BAUD;
  localparam int DW         = 7;
  localparam int WATCHDOG   = 200_000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] tx_data;
  logic          tx_send;
  logic          tx_odd;
  logic          tx_busy;
  logic          txd;

  int tests  = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_tx_frame #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD), .DATA_W(DW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_data (tx_data),
    .tx_send (tx_send),
    .tx_odd  (tx_odd),
    .tx_busy (tx_busy),
    .txd     (txd)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [DW-1:0] d, input logic odd, input int idx);
    if (idx == 0)       return 1'b0;
    else if (idx <= DW) return d[idx-1];
    else if (idx == DW+1) return (^d) ^ odd;
    else                return 1'b1;
  endfunction

  // one full handshake; hold_extra = clocks Send stays high after busy falls
  task automatic send_frame(input logic [DW-1:0] d, input logic odd, input int hold_extra);
    @(negedge clk);
    tx_data = d;
    tx_odd  = odd;
    tx_send = 1'b1;
    @(negedge clk);
    check("R2", tx_busy, 1'b1, "busy after request");
    for (int b = 0; b < DW + 3; b++) begin
      logic bad_line = 1'b0;
      logic bad_busy = 1'b0;
      logic e = exp_bit(d, odd, b);
      for (int c = 0; c < CPB; c++) begin
        if (!(b == 0 && c == 0)) @(negedge clk);
        if (txd !== e)     bad_line = 1'b1;
        if (tx_busy !== 1'b1) bad_busy = 1'b1;
      end
      if (b == 0)       check("R2", bad_line, 1'b0, "start bit level/length");
      else if (b <= DW) check("R3", bad_line, 1'b0, $sformatf("data bit %0d d=%02h", b-1, d));
      else if (b == DW+1) check("R4", bad_line, 1'b0, $sformatf("parity d=%02h odd=%0b", d, odd));
      else              check("R5", bad_line, 1'b0, "stop bit");
      check("R6", bad_busy, 1'b0, $sformatf("busy through bit %0d", b));
    end
    @(negedge clk);
    check("R5", tx_busy, 1'b0, "busy falls after 10 bit periods");
    check("R5", txd, 1'b1, "line high at end");
    if (hold_extra > 0) begin
      logic bad = 1'b0;
      for (int k = 0; k < hold_extra; k++) begin
        @(negedge clk);
        if (tx_busy !== 1'b0 || txd !== 1'b1) bad = 1'b1;
      end
      check("R7", bad, 1'b0, "held request ignored");
    end
    tx_send = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    rst_n   = 1'b0;
    tx_send = 1'b0;
    tx_odd  = 1'b0;
    tx_data = '0;
    repeat (3) @(negedge clk);
    check("R1", txd, 1'b1, "line in reset");
    check("R1", tx_busy, 1'b0, "busy in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", txd, 1'b1, "line after reset");
    check("R1", tx_busy, 1'b0, "busy after reset");

    // long hold of Send after completion
    send_frame(7'h57, 1'b1, 3 * CPB);
    repeat (4) @(negedge clk);
    check("R1", txd, 1'b1, "idle line between frames");
    send_frame(7'h00, 1'b0, 5);
    send_frame(7'h7F, 1'b1, 5);

    // exhaustive sweep, request re-raised right after release (R8)
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < (1 << DW); v++) begin
        send_frame(DW'(v), p[0], 0);
      end
    end
    check("R8", tx_busy, 1'b0, "final idle busy");

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule